// File: doc/BRIEF.md
# Master Clock Ratio Detector and Frame Lock Monitor

This block runs in the system (master) clock domain of an audio codec. It watches the frame (left/right) clock and the bit clock, and counts master clock cycles between frame clock rising edges. From that count it classifies the master clock as 256, 384 or 512 times the sample rate. It then produces a clock enable that fires exactly 256 times per sample period, which paces the downstream filter and modulator. For a 384x master clock the enable follows a two-of-three pattern. For a 512x clock it fires on every other cycle.

The same measurement also drives a frame lock monitor. Each frame, the block compares the measured period with the nominal period of the detected ratio. The tolerated deviation is expressed in bit clocks, using the bit clock count of the previous frame. When the frame clock wanders too far, changes ratio, stops, or runs at an unsupported rate, the lock flag drops. At the same frame edge, zero-forcing controls for the playback and capture paths are raised. The zero forces are released only after a fixed run of consecutive well-behaved frames.

Top module: `clk_ratio_sync_mon`

## Requirements
- R1: A frame period of 256, 384 or 512 master cycles (each within ±RATIO_TOL, default 48) is reported on `ratio` as 1, 2 or 3 respectively, from the frame edge that ends that period.
- R2: A frame period outside every tolerance window is reported as `ratio` = 0 and counts as a bad frame (`sync_ok` = 0, both zero forces high).
- R3: While `ratio` is stable, `en_256fs` is high on every cycle for ratio 1, on two of every three cycles for ratio 2, and on alternate cycles for ratio 3, giving 256 enables per sample period.
- R4: While `ratio` is 0, `en_256fs` stays low.
- R5: A frame edge displaced from its nominal position by at most LOSS_BITS (default 5) bit clocks is accepted: `sync_ok` stays 1 and the zero forces are unchanged.
- R6: A frame edge displaced by more than LOSS_BITS bit clocks drops `sync_ok` and raises `play_zero` and `cap_zero` at that frame edge, within one sample period.
- R7: After reset or after any bad frame, `play_zero` and `cap_zero` stay high until HOLD_FRAMES (default 32) consecutive good frames have been measured. They fall at the frame edge that completes the run, and only while `sync_ok` is 1.
- R8: During and right after reset: `ratio` = 0, `en_256fs` = 0, `sync_ok` = 0, `play_zero` = 1, `cap_zero` = 1.
- R9: A frame whose ratio class differs from that of the previous frame is a bad frame, even if its period is valid.
- R10: If no frame edge arrives within 2·BASE_RATIO + RATIO_TOL + 1 master cycles of the last one, `ratio` returns to 0, `sync_ok` drops and both zero forces rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_clk | input | 1 | Frame (left/right) clock, sampled in the clk domain |
| bit_clk | input | 1 | Serial bit clock, sampled in the clk domain |
| ratio | output | 2 | Detected ratio: 0 none, 1 = 256x, 2 = 384x, 3 = 512x |
| en_256fs | output | 1 | Clock enable at 256 times the sample rate |
| sync_ok | output | 1 | Last measured frame was well-formed and on time |
| play_zero | output | 1 | Force the playback path to bipolar zero |
| cap_zero | output | 1 | Force the capture output to zero code |

## Verification
On every cycle, the assertions check the reset values, the enable cadence for each stable ratio, and that enables are silent without a ratio. They also check that the zero forces are high whenever lock is absent, and that the forces rise only on a lock failure and fall only while locked. The bench scenarios are needed for the rest: the exact ratio classification, the 256-enables-per-frame count, the accept/reject boundary of 5 versus 6 bit clocks of drift, the precise 32-frame hold-off, ratio changes, unsupported periods and a stopped frame clock.

// File: rtl/crm_pkg.sv
package crm_pkg;
  typedef enum logic [1:0] {
    RATIO_NONE = 2'd0,
    RATIO_256  = 2'd1,
    RATIO_384  = 2'd2,
    RATIO_512  = 2'd3
  } ratio_e;
endpackage

// File: rtl/crm_edge_sync.sv
// Brings an asynchronous-ish strobe into clk and flags its rising edge.
module crm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      rise  <= 1'b0;
    end else begin
      shreg <= {shreg[STAGES-1:0], din};
      rise  <= shreg[STAGES-1] & ~shreg[STAGES];
    end
  end
endmodule

// File: rtl/crm_period_meter.sv
// Measures master cycles and bit clock edges between frame rising edges.
module crm_period_meter #(
  parameter int CNT_W   = 11,
  parameter int BCNT_W  = 8,
  parameter int TIMEOUT = 561
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_rise,
  input  logic              bit_rise,
  output logic              meas_valid,
  output logic [CNT_W-1:0]  meas_period,
  output logic [BCNT_W-1:0] meas_bclks,
  output logic              timeout
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [BCNT_W-1:0] BCNT_MAX = '1;
  localparam logic [CNT_W-1:0]  TO_VAL   = CNT_W'(TIMEOUT);

  logic              started;
  logic [CNT_W-1:0]  cyc_cnt;
  logic [BCNT_W-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      started     <= 1'b0;
      cyc_cnt     <= '0;
      bit_cnt     <= '0;
      meas_valid  <= 1'b0;
      meas_period <= '0;
      meas_bclks  <= '0;
      timeout     <= 1'b0;
    end else begin
      meas_valid <= 1'b0;
      timeout    <= 1'b0;
      if (frame_rise) begin
        started <= 1'b1;
        cyc_cnt <= CNT_W'(1);
        bit_cnt <= '0;
        if (started) begin
          meas_valid  <= 1'b1;
          meas_period <= cyc_cnt;
          meas_bclks  <= (bit_rise && bit_cnt != BCNT_MAX) ? bit_cnt + 1'b1 : bit_cnt;
        end
      end else begin
        if (cyc_cnt != CNT_MAX) cyc_cnt <= cyc_cnt + 1'b1;
        if (bit_rise && bit_cnt != BCNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        if (started && cyc_cnt == TO_VAL) timeout <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/crm_sync_tracker.sv
// Classifies each measured frame, judges drift and runs the hold-off.
module crm_sync_tracker
  import crm_pkg::*;
#(
  parameter int BASE_RATIO  = 256,
  parameter int RATIO_TOL   = 48,
  parameter int LOSS_BITS   = 5,
  parameter int HOLD_FRAMES = 32,
  parameter int CNT_W       = 11,
  parameter int BCNT_W      = 8,
  parameter int N_PATHS     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_valid,
  input  logic [CNT_W-1:0]  meas_period,
  input  logic [BCNT_W-1:0] meas_bclks,
  input  logic              timeout,
  output ratio_e            ratio_q,
  output logic              sync_ok,
  output logic [N_PATHS-1:0] zero_force
);
  localparam int NOM_A  = BASE_RATIO;
  localparam int NOM_B  = (BASE_RATIO * 3) / 2;
  localparam int NOM_C  = BASE_RATIO * 2;
  localparam int GOOD_W = $clog2(HOLD_FRAMES + 1);
  localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(HOLD_FRAMES);

  ratio_e            prev_cls;
  logic [BCNT_W-1:0] prev_bclks;
  logic [GOOD_W-1:0] good_cnt;

  ratio_e            cls;
  int                nominal;
  int                drift;
  int                period_i;
  logic              good;
  logic [GOOD_W-1:0] good_next;
  logic              release_ok;

  always_comb begin
    period_i = int'(meas_period);
    cls      = RATIO_NONE;
    nominal  = 0;
    if (period_i >= NOM_A - RATIO_TOL && period_i <= NOM_A + RATIO_TOL) begin
      cls = RATIO_256; nominal = NOM_A;
    end else if (period_i >= NOM_B - RATIO_TOL && period_i <= NOM_B + RATIO_TOL) begin
      cls = RATIO_384; nominal = NOM_B;
    end else if (period_i >= NOM_C - RATIO_TOL && period_i <= NOM_C + RATIO_TOL) begin
      cls = RATIO_512; nominal = NOM_C;
    end
    drift = (period_i >= nominal) ? period_i - nominal : nominal - period_i;
    good  = (cls != RATIO_NONE) && (cls == prev_cls) && (prev_bclks != '0) &&
            (drift * int'(prev_bclks) <= LOSS_BITS * nominal);
    if (!good)                  good_next = '0;
    else if (good_cnt == GOOD_MAX) good_next = GOOD_MAX;
    else                        good_next = good_cnt + 1'b1;
    release_ok = good && (good_next == GOOD_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q    <= RATIO_NONE;
      prev_cls   <= RATIO_NONE;
      prev_bclks <= '0;
      sync_ok    <= 1'b0;
      good_cnt   <= '0;
    end else if (timeout) begin
      ratio_q    <= RATIO_NONE;
      prev_cls   <= RATIO_NONE;
      sync_ok    <= 1'b0;
      good_cnt   <= '0;
    end else if (meas_valid) begin
      ratio_q    <= cls;
      prev_cls   <= cls;
      prev_bclks <= meas_bclks;
      sync_ok    <= good;
      good_cnt   <= good_next;
    end
  end

  // One independent zero-force register per audio path.
  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    always_ff @(posedge clk) begin
      if (rst || timeout)  zero_force[p] <= 1'b1;
      else if (meas_valid) zero_force[p] <= ~release_ok;
    end
  end
endmodule

// File: rtl/crm_en_gen.sv
// Derives the 256-fs enable pattern from the detected ratio.
module crm_en_gen
  import crm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  ratio_e ratio,
  output logic   en
);
  logic [1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      en    <= 1'b0;
    end else begin
      unique case (ratio)
        RATIO_256: begin
          en    <= 1'b1;
          phase <= '0;
        end
        RATIO_384: begin
          en    <= (phase != 2'd2);
          phase <= (phase >= 2'd2) ? 2'd0 : phase + 1'b1;
        end
        RATIO_512: begin
          en    <= (phase == 2'd0);
          phase <= (phase == 2'd0) ? 2'd1 : 2'd0;
        end
        default: begin
          en    <= 1'b0;
          phase <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/clk_ratio_sync_mon.sv
module clk_ratio_sync_mon
  import crm_pkg::*;
#(
  parameter int BASE_RATIO  = 256,
  parameter int RATIO_TOL   = 48,
  parameter int LOSS_BITS   = 5,
  parameter int HOLD_FRAMES = 32,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_BCLKS   = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_clk,
  input  logic       bit_clk,
  output logic [1:0] ratio,
  output logic       en_256fs,
  output logic       sync_ok,
  output logic       play_zero,
  output logic       cap_zero
);
  localparam int TIMEOUT = 2 * BASE_RATIO + RATIO_TOL + 1;
  localparam int CNT_W   = $clog2(TIMEOUT + 2);
  localparam int BCNT_W  = $clog2(4 * MAX_BCLKS + 1);

  logic              frame_rise, bit_rise;
  logic              meas_valid, timeout;
  logic [CNT_W-1:0]  meas_period;
  logic [BCNT_W-1:0] meas_bclks;
  ratio_e            ratio_q;
  logic [1:0]        zero_force;

  crm_edge_sync #(.STAGES(SYNC_STAGES)) u_frame_sync (
    .clk(clk), .rst(rst), .din(frame_clk), .rise(frame_rise));

  crm_edge_sync #(.STAGES(SYNC_STAGES)) u_bit_sync (
    .clk(clk), .rst(rst), .din(bit_clk), .rise(bit_rise));

  crm_period_meter #(.CNT_W(CNT_W), .BCNT_W(BCNT_W), .TIMEOUT(TIMEOUT)) u_meter (
    .clk(clk), .rst(rst), .frame_rise(frame_rise), .bit_rise(bit_rise),
    .meas_valid(meas_valid), .meas_period(meas_period),
    .meas_bclks(meas_bclks), .timeout(timeout));

  crm_sync_tracker #(
    .BASE_RATIO(BASE_RATIO), .RATIO_TOL(RATIO_TOL), .LOSS_BITS(LOSS_BITS),
    .HOLD_FRAMES(HOLD_FRAMES), .CNT_W(CNT_W), .BCNT_W(BCNT_W), .N_PATHS(2)
  ) u_tracker (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas_period(meas_period),
    .meas_bclks(meas_bclks), .timeout(timeout), .ratio_q(ratio_q),
    .sync_ok(sync_ok), .zero_force(zero_force));

  crm_en_gen u_en (
    .clk(clk), .rst(rst), .ratio(ratio_q), .en(en_256fs));

  assign ratio     = ratio_q;
  assign play_zero = zero_force[0];
  assign cap_zero  = zero_force[1];
endmodule

// File: rtl/crm_checker.sv
module crm_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] ratio,
  input logic       en_256fs,
  input logic       sync_ok,
  input logic       play_zero,
  input logic       cap_zero
);
  assert_reset_state_R8: assert property (@(posedge clk)
    $past(rst) |-> (ratio == 2'd0 && !en_256fs && !sync_ok && play_zero && cap_zero));

  assert_lock_has_ratio_R1: assert property (@(posedge clk) disable iff (rst)
    sync_ok |-> ratio != 2'd0);

  assert_no_enable_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (ratio == 2'd0) |=> !en_256fs);

  assert_enable_full_R3: assert property (@(posedge clk) disable iff (rst)
    (ratio == 2'd1) |=> en_256fs);

  assert_enable_half_R3: assert property (@(posedge clk) disable iff (rst)
    (ratio == 2'd3 && $past(ratio) == 2'd3 && en_256fs) |=> !en_256fs);

  assert_enable_twothirds_R3: assert property (@(posedge clk) disable iff (rst)
    (ratio == 2'd2 && $past(ratio) == 2'd2 && $past(ratio, 2) == 2'd2 &&
     en_256fs && $past(en_256fs)) |=> !en_256fs);

  assert_zero_when_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
    !sync_ok |-> (play_zero && cap_zero));

  assert_zero_rise_on_loss_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(play_zero) |-> !sync_ok);

  assert_release_locked_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(play_zero) || $fell(cap_zero)) |-> sync_ok);
endmodule

bind clk_ratio_sync_mon crm_checker u_checker (
  .clk(clk), .rst(rst), .ratio(ratio), .en_256fs(en_256fs),
  .sync_ok(sync_ok), .play_zero(play_zero), .cap_zero(cap_zero));

// File: tb/tb_clk_ratio_sync_mon.sv
module tb_clk_ratio_sync_mon;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm = 1'b0;
  logic bck = 1'b0;
  logic [1:0] ratio;
  logic en_256fs, sync_ok, play_zero, cap_zero;

  always #5 clk = ~clk;

  clk_ratio_sync_mon dut (
    .clk(clk), .rst(rst), .frame_clk(frm), .bit_clk(bck), .ratio(ratio),
    .en_256fs(en_256fs), .sync_ok(sync_ok), .play_zero(play_zero), .cap_zero(cap_zero));

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Stimulus generator: frame period gen_p, bit clock period gen_bdiv,
  // one-shot extension gen_extra of the current frame.
  int gen_p = 256, gen_bdiv = 8, gen_extra = 0;
  bit gen_run = 0;
  int pos = 0, gcnt = 0, frames_seen = 0;

  always @(posedge clk) begin
    if (gen_run) begin
      frm <= (pos < gen_p / 2);
      if (pos >= gen_p + gen_extra - 1) begin
        pos = 0; gen_extra = 0; frames_seen++;
      end else pos++;
    end
    bck <= ((gcnt % gen_bdiv) >= gen_bdiv / 2);
    gcnt++;
  end

  typedef struct { string req; int r; bit ok; bit zero; } exp_t;
  exp_t sb_q[$];
  event chk_ev;

  // Monitor: pops expected items and compares with the ports.
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (int'(ratio) != e.r || sync_ok != e.ok || play_zero != e.zero || cap_zero != e.zero) begin
          n_fail++;
          $display("FAIL %s: ratio/sync_ok/play_zero/cap_zero = %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
                   e.req, ratio, sync_ok, play_zero, cap_zero, e.r, e.ok, e.zero, e.zero);
        end
      end
    end
  end

  task automatic expect_state(input string req, input int r, input bit ok, input bit zero);
    exp_t e;
    e.req = req; e.r = r; e.ok = ok; e.zero = zero;
    sb_q.push_back(e);
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic wait_frames(input int n);
    int target;
    target = frames_seen + n;
    while (frames_seen < target) @(negedge clk);
    repeat (gen_p / 4) @(negedge clk);
  endtask

  task automatic count_en(input string req, input int cycles, input int expv);
    int cnt;
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      if (en_256fs) cnt++;
      @(negedge clk);
    end
    n_checks++;
    if (cnt != expv) begin
      n_fail++;
      $display("FAIL %s: enables in window = %0d expected %0d", req, cnt, expv);
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    expect_state("R8", 0, 0, 1);
    count_en("R8", 4, 0);
    rst = 1'b0;
    gen_run = 1;

    // 256x, 32 bit clocks per frame
    wait_frames(4);
    expect_state("R1", 1, 1, 1);
    count_en("R3", gen_p, 256);
    wait_frames(40);
    expect_state("R7", 1, 1, 0);
    gen_extra = 40;                       // exactly 5 bit clocks
    wait_frames(1);
    expect_state("R5", 1, 1, 0);
    wait_frames(2);
    gen_extra = 48;                       // 6 bit clocks
    wait_frames(1);
    expect_state("R6", 1, 0, 1);
    wait_frames(31);
    expect_state("R7", 1, 1, 1);
    wait_frames(1);
    expect_state("R7", 1, 1, 0);

    // 384x, 48 bit clocks per frame
    gen_p = 384;
    wait_frames(1);
    expect_state("R9", 2, 0, 1);
    wait_frames(1);
    expect_state("R1", 2, 1, 1);
    count_en("R3", gen_p, 256);
    wait_frames(40);
    expect_state("R7", 2, 1, 0);
    gen_extra = 40;
    wait_frames(1);
    expect_state("R5", 2, 1, 0);

    // 512x, 64 bit clocks per frame
    gen_p = 512;
    wait_frames(1);
    expect_state("R9", 3, 0, 1);
    wait_frames(1);
    expect_state("R1", 3, 1, 1);
    count_en("R3", gen_p, 256);
    wait_frames(40);
    expect_state("R7", 3, 1, 0);
    gen_extra = 48;
    wait_frames(1);
    expect_state("R6", 3, 0, 1);

    // unsupported period
    gen_p = 160;
    wait_frames(2);
    expect_state("R2", 0, 0, 1);
    count_en("R4", gen_p, 0);

    // recover, then stop the frame clock
    gen_p = 512;
    wait_frames(3);
    expect_state("R1", 3, 1, 1);
    gen_run = 0;
    repeat (800) @(negedge clk);
    expect_state("R10", 0, 0, 1);
    count_en("R4", 64, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule